// File: doc/BRIEF.md
# Sleep-State Power Rail Sequencer

This controller decides whether a memory power subsystem is off (S5), running (S0) or sleeping (S3). It reads two active-low sleep requests and a set of digital health flags: reference good, standby supply good, boot supply good, over-current trip, over-temperature, and main rail in regulation. From these it drives the enable and mode of three rails. These are a main switching rail, a termination rail that tracks half of the main rail, and an auxiliary switching rail. The analog monitors and the regulators themselves sit outside this block.

On a cold start only the main rail soft-starts. The termination and auxiliary rails wait until that soft-start has finished and a debounced in-regulation flag is seen. In sleep the main rail is kept alive in standby while the other two rails drop. On wake only the auxiliary rail repeats its soft-start, which is half as long as the main one. An over-current trip latches everything off until a supply or the off request is cycled. An over-temperature flag holds everything off only for as long as it is high.

Top module: `sleep_seq`

## Requirements
- R1: After reset, and whenever `ref_ok` or `stby_ok` is low, the state is S5 (code 0), with main_mode OFF (0), term_mode HIZ (3), aux_mode OFF (0), and both soft-start flags low.
- R2: From S5 the state moves to S0 (code 1) on the next edge only when `sleep5_n`, `sleep3_n` and `boot_ok` are all high. Otherwise it stays in S5.
- R3: In S0, `sleep3_n` low with `sleep5_n` high moves the state to S3 (code 2) on the next edge. Losing `boot_ok` while in S3 leaves the state in S3.
- R4: In S3, `sleep3_n` high with `boot_ok` high returns the state to S0. `sleep3_n` high with `boot_ok` low causes no change.
- R5: `sleep5_n` low moves S0 or S3 to S5 on the next edge. In S0, `sleep3_n` high with `boot_ok` low also moves to S5.
- R6: On S5→S0 only the main rail soft-starts: `main_ss` stays high for MAIN_SS_CYC cycles while term_mode stays HIZ and aux_mode stays OFF. Both stay there until the soft-start is over and the in-regulation flag is qualified.
- R7: `main_inreg` counts as qualified only after DEB_CYC consecutive high cycles. A one-cycle pulse never enables the dependent rails.
- R8: Once main regulation is qualified, term_mode and aux_mode become NORMAL (1) on the next edge. `aux_ss` is then high for MAIN_SS_CYC/2 cycles and never overlaps `main_ss`.
- R9: Mode table: S0 with sequencing done gives all rails NORMAL. S3 gives main STANDBY (2), term HIZ and aux OFF.
- R10: On S3→S0 the main rail stays NORMAL with no `main_ss`. The auxiliary soft-start starts at once, and term_mode becomes NORMAL in the same cycle.
- R11: `ovc_trip` in S0 sends the state to S5 on the next edge and latches there. In S3 it is ignored. The latch clears only when `stby_ok`, `sleep5_n` or `boot_ok` goes low.
- R12: While `therm_hot` is high the state is S5 from the next edge on. Once it clears, normal entry to S0 resumes.
- R13: When `ovc_trip` and a sleep request arrive in the same S0 cycle, the fault wins: the next state is S5 and the latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_ok | input | 1 | Reference good |
| stby_ok | input | 1 | Standby supply good |
| boot_ok | input | 1 | Boot (gate-drive) supply good |
| sleep5_n | input | 1 | Active-low off request |
| sleep3_n | input | 1 | Active-low sleep request |
| ovc_trip | input | 1 | Main rail over-current detected |
| therm_hot | input | 1 | Over-temperature, hysteresis applied outside |
| main_inreg | input | 1 | Main rail in regulation |
| state | output | 2 | 0=S5, 1=S0, 2=S3 |
| main_mode | output | 2 | 0=OFF, 1=NORMAL, 2=STANDBY |
| main_ss | output | 1 | Main rail soft-start active |
| term_mode | output | 2 | 1=NORMAL, 3=HIZ |
| aux_mode | output | 2 | 0=OFF (both gates low), 1=NORMAL |
| aux_ss | output | 1 | Auxiliary soft-start active |

## Verification
The collision that matters here is an over-current trip landing in the same S0 cycle as a sleep request. The fault latch and the S3 transition would then both claim the next state. The bench drops `sleep3_n` and raises `ovc_trip` on the same edge. It expects S5, not S3, with all rails off, and it expects the state to stay in S5 after the trip is removed. That proves the latch was set. Recovery is judged only after `boot_ok` is cycled.

// File: rtl/sleep_seq.sv
module sleep_seq #(
  parameter int MAIN_SS_CYC = 16,
  parameter int DEB_CYC     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_ok,
  input  logic       stby_ok,
  input  logic       boot_ok,
  input  logic       sleep5_n,
  input  logic       sleep3_n,
  input  logic       ovc_trip,
  input  logic       therm_hot,
  input  logic       main_inreg,
  output logic [1:0] state,
  output logic [1:0] main_mode,
  output logic       main_ss,
  output logic [1:0] term_mode,
  output logic [1:0] aux_mode,
  output logic       aux_ss
);
  localparam int AUX_SS_CYC = MAIN_SS_CYC / 2;
  localparam int CW = $clog2(MAIN_SS_CYC + 1);
  localparam int DW = $clog2(DEB_CYC + 1);
  localparam logic [1:0] ST_S5 = 2'd0, ST_S0 = 2'd1, ST_S3 = 2'd2;
  localparam logic [1:0] M_OFF = 2'd0, M_NRM = 2'd1, M_STB = 2'd2, M_HIZ = 2'd3;
  localparam logic [1:0] P_MSS = 2'd0, P_WAIT = 2'd1, P_AUX = 2'd2, P_UP = 2'd3;

  logic [1:0]    st_q, nxt, phase;
  logic [CW-1:0] cnt;
  logic [DW-1:0] deb;
  logic          flt;

  wire in_s0    = (st_q == ST_S0);
  wire inreg_ok = (deb == DW'(DEB_CYC));
  wire kill     = !ref_ok || !stby_ok || therm_hot || flt || (ovc_trip && in_s0);
  wire flt_clr  = !stby_ok || !sleep5_n || !boot_ok;
  wire rails_up = in_s0 && (phase == P_AUX || phase == P_UP);

  always_comb begin
    nxt = st_q;
    if (kill) nxt = ST_S5;
    else begin
      case (st_q)
        ST_S5: if (sleep5_n && sleep3_n && boot_ok) nxt = ST_S0;
        ST_S0: if (!sleep5_n) nxt = ST_S5;
               else if (!sleep3_n) nxt = ST_S3;
               else if (!boot_ok) nxt = ST_S5;
        ST_S3: if (!sleep5_n) nxt = ST_S5;
               else if (sleep3_n && boot_ok) nxt = ST_S0;
        default: nxt = ST_S5;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_S5;
      phase <= P_MSS;
      cnt   <= '0;
      deb   <= '0;
      flt   <= 1'b0;
    end else begin
      st_q <= nxt;
      flt  <= flt_clr ? 1'b0 : (flt || (ovc_trip && in_s0));
      if (in_s0 && main_inreg) deb <= inreg_ok ? deb : deb + 1'b1;
      else deb <= '0;
      if (!in_s0 && nxt == ST_S0) begin
        phase <= (st_q == ST_S3) ? P_AUX : P_MSS;
        cnt   <= '0;
      end else if (in_s0) begin
        case (phase)
          P_MSS:  if (cnt == CW'(MAIN_SS_CYC - 1)) begin phase <= P_WAIT; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
          P_WAIT: if (inreg_ok) begin phase <= P_AUX; cnt <= '0; end
          P_AUX:  if (cnt == CW'(AUX_SS_CYC - 1)) begin phase <= P_UP; cnt <= '0; end
                  else cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign state     = st_q;
  assign main_mode = in_s0 ? M_NRM : (st_q == ST_S3) ? M_STB : M_OFF;
  assign main_ss   = in_s0 && phase == P_MSS;
  assign term_mode = rails_up ? M_NRM : M_HIZ;
  assign aux_mode  = rails_up ? M_NRM : M_OFF;
  assign aux_ss    = in_s0 && phase == P_AUX;
endmodule

// File: rtl/sleep_seq_chk.sv
module sleep_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_ok,
  input logic       therm_hot,
  input logic       sleep5_n,
  input logic       sleep3_n,
  input logic       boot_ok,
  input logic       ovc_trip,
  input logic [1:0] state,
  input logic [1:0] main_mode,
  input logic       main_ss,
  input logic [1:0] term_mode,
  input logic [1:0] aux_mode,
  input logic       aux_ss
);
  assert_s5_rails_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 |-> main_mode == 2'd0 && aux_mode == 2'd0 && term_mode == 2'd3);
  assert_aux_after_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_mode == 2'd1 |-> main_mode == 2'd1 && term_mode == 2'd1 && !main_ss);
  assert_ss_disjoint_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(main_ss && aux_ss));
  assert_ovc_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd1 && ovc_trip |=> state == 2'd0);
  assert_therm_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
    therm_hot |=> state == 2'd0);
  assert_off_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep5_n |=> state == 2'd0);
  assert_ref_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |=> state == 2'd0);
  assert_s5_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 && !(sleep5_n && sleep3_n && boot_ok) |=> state == 2'd0);
endmodule

bind sleep_seq sleep_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .therm_hot(therm_hot),
  .sleep5_n(sleep5_n), .sleep3_n(sleep3_n), .boot_ok(boot_ok), .ovc_trip(ovc_trip),
  .state(state), .main_mode(main_mode), .main_ss(main_ss),
  .term_mode(term_mode), .aux_mode(aux_mode), .aux_ss(aux_ss)
);

// File: tb/sleep_seq_tb_top.sv
module sleep_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_ok = 0, stby_ok = 0, boot_ok = 0, sleep5_n = 1, sleep3_n = 1;
  logic ovc_trip = 0, therm_hot = 0, main_inreg = 0;
  logic [1:0] state, main_mode, term_mode, aux_mode;
  logic main_ss, aux_ss;

  localparam logic [1:0] S5 = 2'd0, S0 = 2'd1, S3 = 2'd2;
  localparam logic [1:0] OFF = 2'd0, NRM = 2'd1, STB = 2'd2, HIZ = 2'd3;

  always #5 clk = ~clk;

  sleep_seq #(.MAIN_SS_CYC(16), .DEB_CYC(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok(ref_ok), .stby_ok(stby_ok), .boot_ok(boot_ok),
    .sleep5_n(sleep5_n), .sleep3_n(sleep3_n), .ovc_trip(ovc_trip), .therm_hot(therm_hot),
    .main_inreg(main_inreg), .state(state), .main_mode(main_mode), .main_ss(main_ss),
    .term_mode(term_mode), .aux_mode(aux_mode), .aux_ss(aux_ss));

  typedef struct {
    logic [9:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t e;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input logic [1:0] st, input logic [1:0] mm,
                            input logic mss, input logic [1:0] tm, input logic [1:0] am,
                            input logic ass);
    exp_t x;
    x.v = {st, mm, mss, tm, am, ass};
    x.tag = tag;
    q.push_back(x);
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if ({state, main_mode, main_ss, term_mode, aux_mode, aux_ss} !== e.v) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", e.tag,
                 {state, main_mode, main_ss, term_mode, aux_mode, aux_ss}, e.v);
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    expect_out("R1 reset", S5, OFF, 0, HIZ, OFF, 0);
    ref_ok = 1; boot_ok = 1;
    tick(3);
    expect_out("R1 standby bad", S5, OFF, 0, HIZ, OFF, 0);
    stby_ok = 1; boot_ok = 0;
    tick(2);
    expect_out("R2 boot bad", S5, OFF, 0, HIZ, OFF, 0);
    boot_ok = 1;
    tick(1);
    expect_out("R2 R6 enter S0", S0, NRM, 1, HIZ, OFF, 0);
    tick(15);
    expect_out("R6 main ss end", S0, NRM, 1, HIZ, OFF, 0);
    tick(1);
    expect_out("R6 wait inreg", S0, NRM, 0, HIZ, OFF, 0);
    main_inreg = 1; tick(1); main_inreg = 0; tick(4);
    expect_out("R7 glitch", S0, NRM, 0, HIZ, OFF, 0);
    main_inreg = 1;
    tick(3);
    expect_out("R7 debounce", S0, NRM, 0, HIZ, OFF, 0);
    tick(1);
    expect_out("R8 aux start", S0, NRM, 0, NRM, NRM, 1);
    tick(7);
    expect_out("R8 aux ss len", S0, NRM, 0, NRM, NRM, 1);
    tick(1);
    expect_out("R9 all normal", S0, NRM, 0, NRM, NRM, 0);
    sleep3_n = 0;
    tick(1);
    expect_out("R3 R9 enter S3", S3, STB, 0, HIZ, OFF, 0);
    boot_ok = 0;
    tick(2);
    expect_out("R3 boot loss in S3", S3, STB, 0, HIZ, OFF, 0);
    sleep3_n = 1;
    tick(2);
    expect_out("R4 no boot", S3, STB, 0, HIZ, OFF, 0);
    sleep3_n = 0; boot_ok = 1;
    tick(1);
    ovc_trip = 1; tick(1); ovc_trip = 0; tick(1);
    expect_out("R11 ovc ignored S3", S3, STB, 0, HIZ, OFF, 0);
    sleep3_n = 1;
    tick(1);
    expect_out("R4 R10 wake", S0, NRM, 0, NRM, NRM, 1);
    tick(7);
    expect_out("R10 aux ss", S0, NRM, 0, NRM, NRM, 1);
    tick(1);
    expect_out("R10 up", S0, NRM, 0, NRM, NRM, 0);
    therm_hot = 1;
    tick(1);
    expect_out("R12 hot", S5, OFF, 0, HIZ, OFF, 0);
    tick(3);
    expect_out("R12 hold", S5, OFF, 0, HIZ, OFF, 0);
    therm_hot = 0;
    tick(1);
    expect_out("R12 resume", S0, NRM, 1, HIZ, OFF, 0);
    tick(16);
    expect_out("R6 wait after ss", S0, NRM, 0, HIZ, OFF, 0);
    tick(1);
    expect_out("R8 aux after wait", S0, NRM, 0, NRM, NRM, 1);
    tick(8);
    ovc_trip = 1; tick(1); ovc_trip = 0;
    expect_out("R11 trip", S5, OFF, 0, HIZ, OFF, 0);
    tick(3);
    expect_out("R11 latched", S5, OFF, 0, HIZ, OFF, 0);
    sleep5_n = 0; tick(1); sleep5_n = 1; tick(1);
    expect_out("R11 cleared by off req", S0, NRM, 1, HIZ, OFF, 0);
    tick(25);
    expect_out("R9 up again", S0, NRM, 0, NRM, NRM, 0);
    sleep3_n = 0; ovc_trip = 1;
    tick(1);
    expect_out("R13 fault wins", S5, OFF, 0, HIZ, OFF, 0);
    ovc_trip = 0; sleep3_n = 1;
    tick(2);
    expect_out("R13 latched", S5, OFF, 0, HIZ, OFF, 0);
    boot_ok = 0; tick(1); boot_ok = 1; tick(1);
    expect_out("R11 cleared by boot", S0, NRM, 1, HIZ, OFF, 0);
    sleep5_n = 0;
    tick(1);
    expect_out("R5 off from S0", S5, OFF, 0, HIZ, OFF, 0);
    sleep5_n = 1;
    tick(1);
    boot_ok = 0;
    tick(1);
    expect_out("R5 boot loss S0", S5, OFF, 0, HIZ, OFF, 0);
    boot_ok = 1;
    tick(1);
    sleep3_n = 0;
    tick(1);
    expect_out("R3 S3 again", S3, STB, 0, HIZ, OFF, 0);
    sleep5_n = 0;
    tick(1);
    expect_out("R5 off from S3", S5, OFF, 0, HIZ, OFF, 0);
    sleep5_n = 1; sleep3_n = 1;
    tick(1);
    ref_ok = 0;
    tick(1);
    expect_out("R1 ref loss", S5, OFF, 0, HIZ, OFF, 0);
    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule